// File: doc/BRIEF.md
# Idle-Period Power Mode Controller

This block decides, lane by lane, how far a group of SIMD execution lanes may drop their supply while they sit idle. Every cycle it receives the set of lanes the issue stage wants right now and a short look-ahead mask of the lanes that upcoming issue slots will need. A lane can go idle in two ways: divergence masks it out of an issued warp, or no warp is ready to issue at all. Both show up as a deasserted request bit.

Each lane keeps a history estimate of how long its idle periods last. That estimate picks the deepest mode the lane may reach: light voltage scaling for short periods, deep voltage scaling for medium ones, and power gating for long ones. Power gating is used only past a break-even length. While the lane stays idle it steps down one mode per cycle. A request or a look-ahead hit sends it straight back to nominal and starts a wake-up countdown. Until that countdown has run out, a request for the lane holds issue.

A static configuration input selects between two variants. The power-leaning variant starts stepping down on the first idle cycle. The performance-leaning variant waits one look-ahead window and stops one mode shallower. Cumulative per-mode residency counters report lane-cycles spent in each mode.

Top module: `ipm_power_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, every lane reports mode 00, issue hold and all wake-up requests are low, and all four residency counters read zero.
- R2: Lane modes are 00 nominal, 01 light scaling, 10 deep scaling and 11 gated. An idle lane's mode grows by exactly one step per cycle at most and never skips a level.
- R3: The deepest allowed mode comes from the lane's predicted idle length P. P < SHORT_TH (8) gives 01. SHORT_TH <= P < LONG_TH (24) gives 10. P >= LONG_TH gives 11 only when P > BREAK_EVEN (14), otherwise 10.
- R4: With the configuration input at 1 (power-leaning), a lane may step down from its first idle cycle. With it at 0 (performance-leaning), a lane steps down only after WINDOW (4) consecutive idle cycles, and the limit from R3 is one step shallower but never below 01.
- R5: The look-ahead input has WINDOW slots of one bit per lane, with bit s*NUM_LANES+l meaning lane l is needed s+1 cycles ahead. A lane with any bit set never steps down that cycle. If it is in a reduced mode, it reads 00 on the next cycle and its wake-up countdown starts.
- R6: A request for a lane in a reduced mode sets that lane's mode to 00 on the next cycle.
- R7: Wake-up takes 1 cycle from 01, 2 cycles from 10 and 4 cycles from 11. Issue hold is high in a cycle whenever some requested lane is not nominal or is still counting down. Under a continuous request, the hold lasts exactly that latency.
- R8: A lane's wake-up request is high while it is in a reduced mode with a request or a look-ahead hit, and in every cycle in which its countdown is still running.
- R9: When a request ends an idle run of I cycles, the prediction becomes floor((P + I) / 2). The idle count saturates at its maximum.
- R10: Residency counter m (bits m*CNT_W upward) adds, at every clock edge out of reset, the number of lanes whose mode was m in that cycle, and saturates at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aggr_i | input | 1 | Static variant select: 1 power-leaning, 0 performance-leaning |
| lane_req_i | input | NUM_LANES | Lanes the issue stage wants this cycle |
| peek_need_i | input | WINDOW*NUM_LANES | Look-ahead: lanes needed in each of the next WINDOW slots |
| lane_mode_o | output | 2*NUM_LANES | Per-lane power mode, two bits per lane |
| wake_req_o | output | NUM_LANES | Per-lane wake-up request to the supply control |
| issue_hold_o | output | 1 | Stall issue: a wanted lane is not yet usable |
| residency_o | output | 4*CNT_W | Per-mode lane-cycle counters, mode 0 in the low bits |

## Verification
Two events can land on the same lane in the same cycle: stepping down into a deeper mode, and a wake trigger from a request or a look-ahead hit. The wake must win. The bench provokes this collision with random idle runs cut short by sparse requests and look-ahead bits, in both variants. It compares every mode, the hold, the wake-up requests and the counters each cycle against an arithmetic model. Directed runs then train the predictor to short, medium and long periods, count the hold cycles out of each mode, and wake a gated lane through the look-ahead ahead of its request.

// File: rtl/ipm_pkg.sv
package ipm_pkg;

    typedef enum logic [1:0] {
        MODE_NOM   = 2'b00,
        MODE_LIGHT = 2'b01,
        MODE_DEEP  = 2'b10,
        MODE_GATED = 2'b11
    } pwr_mode_e;

    // cycles a lane needs to return to nominal from a given mode
    function automatic logic [2:0] wake_latency(pwr_mode_e m);
        case (m)
            MODE_LIGHT: return 3'd1;
            MODE_DEEP:  return 3'd2;
            MODE_GATED: return 3'd4;
            default:    return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/ipm_mode_target.sv
module ipm_mode_target #(
    parameter int IDLE_W     = 8,
    parameter int SHORT_TH   = 8,
    parameter int LONG_TH    = 24,
    parameter int BREAK_EVEN = 14
) (
    input  logic [IDLE_W-1:0] pred_i,
    input  logic              aggr_i,
    output logic [1:0]        target_o
);
    localparam logic [IDLE_W-1:0] SHORT_V = IDLE_W'(SHORT_TH);
    localparam logic [IDLE_W-1:0] LONG_V  = IDLE_W'(LONG_TH);
    localparam logic [IDLE_W-1:0] BE_V    = IDLE_W'(BREAK_EVEN);

    logic [1:0] raw;

    always_comb begin
        if (pred_i < SHORT_V) begin
            raw = 2'd1;
        end else if (pred_i < LONG_V) begin
            raw = 2'd2;
        end else if (pred_i > BE_V) begin
            raw = 2'd3;
        end else begin
            raw = 2'd2;
        end
        // performance variant stops one level shallower
        if (!aggr_i && raw > 2'd1) begin
            target_o = raw - 2'd1;
        end else begin
            target_o = raw;
        end
    end

endmodule

// File: rtl/ipm_lane_ctrl.sv
module ipm_lane_ctrl
    import ipm_pkg::*;
#(
    parameter int IDLE_W     = 8,
    parameter int SHORT_TH   = 8,
    parameter int LONG_TH    = 24,
    parameter int BREAK_EVEN = 14,
    parameter int WINDOW     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       aggr_i,
    input  logic       req_i,
    input  logic       soon_i,
    output logic [1:0] mode_o,
    output logic       ready_o,
    output logic       wake_o
);
    localparam logic [IDLE_W-1:0] IDLE_MAX = '1;
    localparam logic [IDLE_W-1:0] WAIT_V   = IDLE_W'(WINDOW);

    typedef struct packed {
        pwr_mode_e         mode;
        logic [IDLE_W-1:0] idle;
        logic [IDLE_W-1:0] pred;
        logic [2:0]        wake;
    } lane_st_t;

    lane_st_t   st_d, st_q;
    logic [1:0] target;
    logic       wake_trig;
    logic       may_deepen;
    logic [IDLE_W:0] avg_sum;

    ipm_mode_target #(
        .IDLE_W    (IDLE_W),
        .SHORT_TH  (SHORT_TH),
        .LONG_TH   (LONG_TH),
        .BREAK_EVEN(BREAK_EVEN)
    ) target_i (
        .pred_i  (st_q.pred),
        .aggr_i  (aggr_i),
        .target_o(target)
    );

    always_comb begin
        st_d      = st_q;
        wake_trig = (st_q.mode != MODE_NOM) && (req_i || soon_i);
        may_deepen = !req_i && !soon_i && (st_q.wake == 3'd0) &&
                     (st_q.mode < target) &&
                     (aggr_i || (st_q.idle >= WAIT_V));
        avg_sum   = {1'b0, st_q.pred} + {1'b0, st_q.idle};

        if (st_q.wake != 3'd0) begin
            st_d.wake = st_q.wake - 3'd1;
        end

        // idle-run tracking and prediction update
        if (req_i) begin
            st_d.idle = '0;
            if (st_q.idle != '0) begin
                st_d.pred = avg_sum[IDLE_W:1];
            end
        end else if (st_q.idle != IDLE_MAX) begin
            st_d.idle = st_q.idle + 1'b1;
        end

        // waking has priority over stepping down
        if (wake_trig) begin
            st_d.mode = MODE_NOM;
            st_d.wake = wake_latency(st_q.mode) - 3'd1;
        end else if (may_deepen) begin
            st_d.mode = pwr_mode_e'(st_q.mode + 2'd1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o  = st_q.mode;
    assign ready_o = (st_q.mode == MODE_NOM) && (st_q.wake == 3'd0);
    assign wake_o  = wake_trig || (st_q.wake != 3'd0);

endmodule

// File: rtl/ipm_residency.sv
module ipm_residency #(
    parameter int NUM_LANES = 4,
    parameter int CNT_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*NUM_LANES-1:0] modes_i,
    output logic [4*CNT_W-1:0]     cnt_o
);
    localparam int LCW = $clog2(NUM_LANES + 1);

    typedef struct packed {
        logic [3:0][CNT_W-1:0] cnt;
    } res_st_t;

    res_st_t st_d, st_q;

    always_comb begin
        logic [LCW-1:0] n;
        logic [CNT_W:0] sum;
        st_d = st_q;
        for (int m = 0; m < 4; m++) begin
            n = '0;
            for (int l = 0; l < NUM_LANES; l++) begin
                if (modes_i[2*l +: 2] == 2'(m)) begin
                    n = n + LCW'(1);
                end
            end
            sum = {1'b0, st_q.cnt[m]} + (CNT_W+1)'(n);
            st_d.cnt[m] = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar m = 0; m < 4; m++) begin : g_out
        assign cnt_o[m*CNT_W +: CNT_W] = st_q.cnt[m];
    end

endmodule

// File: rtl/ipm_power_ctrl.sv
module ipm_power_ctrl #(
    parameter int NUM_LANES  = 4,
    parameter int WINDOW     = 4,
    parameter int SHORT_TH   = 8,
    parameter int LONG_TH    = 24,
    parameter int BREAK_EVEN = 14,
    parameter int IDLE_W     = 8,
    parameter int CNT_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          aggr_i,
    input  logic [NUM_LANES-1:0]          lane_req_i,
    input  logic [WINDOW*NUM_LANES-1:0]   peek_need_i,
    output logic [2*NUM_LANES-1:0]        lane_mode_o,
    output logic [NUM_LANES-1:0]          wake_req_o,
    output logic                          issue_hold_o,
    output logic [4*CNT_W-1:0]            residency_o
);
    logic [NUM_LANES-1:0] soon;
    logic [NUM_LANES-1:0] ready;

    // any look-ahead slot needing the lane counts as a hit
    always_comb begin
        soon = '0;
        for (int s = 0; s < WINDOW; s++) begin
            soon = soon | peek_need_i[s*NUM_LANES +: NUM_LANES];
        end
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        ipm_lane_ctrl #(
            .IDLE_W    (IDLE_W),
            .SHORT_TH  (SHORT_TH),
            .LONG_TH   (LONG_TH),
            .BREAK_EVEN(BREAK_EVEN),
            .WINDOW    (WINDOW)
        ) lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .aggr_i (aggr_i),
            .req_i  (lane_req_i[l]),
            .soon_i (soon[l]),
            .mode_o (lane_mode_o[2*l +: 2]),
            .ready_o(ready[l]),
            .wake_o (wake_req_o[l])
        );
    end

    assign issue_hold_o = |(lane_req_i & ~ready);

    ipm_residency #(
        .NUM_LANES(NUM_LANES),
        .CNT_W    (CNT_W)
    ) res_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .modes_i(lane_mode_o),
        .cnt_o  (residency_o)
    );

endmodule

// File: rtl/ipm_power_ctrl_chk.sv
module ipm_power_ctrl_chk #(
    parameter int NUM_LANES = 4,
    parameter int WINDOW    = 4,
    parameter int CNT_W     = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_LANES-1:0]        lane_req_i,
    input logic [WINDOW*NUM_LANES-1:0] peek_need_i,
    input logic [2*NUM_LANES-1:0]      lane_mode_o,
    input logic [NUM_LANES-1:0]        wake_req_o,
    input logic                        issue_hold_o,
    input logic [4*CNT_W-1:0]          residency_o
);
    logic [NUM_LANES-1:0] hit;

    always_comb begin
        hit = '0;
        for (int l = 0; l < NUM_LANES; l++) begin
            for (int s = 0; s < WINDOW; s++) begin
                if (peek_need_i[s*NUM_LANES + l]) hit[l] = 1'b1;
            end
        end
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_chk
        assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_mode_o[2*l +: 2] > $past(lane_mode_o[2*l +: 2])) |->
            (lane_mode_o[2*l +: 2] == $past(lane_mode_o[2*l +: 2]) + 2'd1));

        assert_peek_nominal_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(hit[l]) |-> (lane_mode_o[2*l +: 2] == 2'b00));

        assert_req_nominal_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(lane_req_i[l]) |-> (lane_mode_o[2*l +: 2] == 2'b00));

        assert_hold_reduced_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_req_i[l] && lane_mode_o[2*l +: 2] != 2'b00) |-> issue_hold_o);

        assert_wake_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ((lane_req_i[l] || hit[l]) && lane_mode_o[2*l +: 2] != 2'b00) |-> wake_req_o[l]);
    end

    for (genvar m = 0; m < 4; m++) begin : g_res_chk
        assert_res_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
            residency_o[m*CNT_W +: CNT_W] >= $past(residency_o[m*CNT_W +: CNT_W]));
    end

endmodule

bind ipm_power_ctrl ipm_power_ctrl_chk #(
    .NUM_LANES(NUM_LANES),
    .WINDOW   (WINDOW),
    .CNT_W    (CNT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lane_req_i  (lane_req_i),
    .peek_need_i (peek_need_i),
    .lane_mode_o (lane_mode_o),
    .wake_req_o  (wake_req_o),
    .issue_hold_o(issue_hold_o),
    .residency_o (residency_o)
);

// File: tb/ipm_power_ctrl_tb.sv
module ipm_power_ctrl_tb_top;
    localparam int N  = 4;
    localparam int W  = 4;
    localparam int CW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            aggr = 1'b1;
    logic [N-1:0]    lane_req = '0;
    logic [W*N-1:0]  peek = '0;
    logic [2*N-1:0]  lane_mode;
    logic [N-1:0]    wake_req;
    logic            issue_hold;
    logic [4*CW-1:0] residency;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit last_hold;

    int m_mode[N];
    int m_idle[N];
    int m_pred[N];
    int m_wake[N];
    int m_res[4];

    always #10 clk = ~clk;

    ipm_power_ctrl #(.NUM_LANES(N), .WINDOW(W), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .aggr_i(aggr), .lane_req_i(lane_req),
        .peek_need_i(peek), .lane_mode_o(lane_mode), .wake_req_o(wake_req),
        .issue_hold_o(issue_hold), .residency_o(residency));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int lat(input int m);
        return (m == 1) ? 1 : (m == 2) ? 2 : (m == 3) ? 4 : 0;
    endfunction

    function automatic int limit_of(input int p, input bit a);
        int r;
        if (p < 8) r = 1;
        else if (p < 24) r = 2;
        else if (p > 14) r = 3;
        else r = 2;
        if (!a && r > 1) r = r - 1;
        return r;
    endfunction

    function automatic int mode_of(input int l);
        return int'(lane_mode[2*l +: 2]);
    endfunction

    // one cycle: drive, check combinational outputs, advance model, check state
    task automatic step(input logic [N-1:0] rq, input logic [W*N-1:0] pk);
        int nm[N]; int ni[N]; int np[N]; int nw[N];
        bit eh; bit hit; bit ew;
        lane_req = rq;
        peek = pk;
        #5;
        eh = 1'b0;
        for (int l = 0; l < N; l++) begin
            hit = 1'b0;
            for (int s = 0; s < W; s++) hit |= pk[s*N + l];
            ew = (m_mode[l] != 0 && (rq[l] || hit)) || m_wake[l] != 0;
            chk(wake_req[l] == ew, "R8 wake request", int'(wake_req[l]), int'(ew));
            if (rq[l] && !(m_mode[l] == 0 && m_wake[l] == 0)) eh = 1'b1;
            nm[l] = m_mode[l];
            nw[l] = (m_wake[l] > 0) ? m_wake[l] - 1 : 0;
            ni[l] = m_idle[l];
            np[l] = m_pred[l];
            if (rq[l]) begin
                ni[l] = 0;
                if (m_idle[l] != 0) np[l] = (m_pred[l] + m_idle[l]) / 2;
            end else if (m_idle[l] < 255) begin
                ni[l] = m_idle[l] + 1;
            end
            if (m_mode[l] != 0 && (rq[l] || hit)) begin
                nm[l] = 0;
                nw[l] = lat(m_mode[l]) - 1;
            end else if (!rq[l] && !hit && m_wake[l] == 0 &&
                         m_mode[l] < limit_of(m_pred[l], aggr) &&
                         (aggr || m_idle[l] >= W)) begin
                nm[l] = m_mode[l] + 1;
            end
        end
        chk(issue_hold == eh, "R7 issue hold", int'(issue_hold), int'(eh));
        last_hold = issue_hold;
        for (int l = 0; l < N; l++) m_res[m_mode[l]]++;
        @(posedge clk);
        #2;
        for (int l = 0; l < N; l++) begin
            m_mode[l] = nm[l]; m_idle[l] = ni[l]; m_pred[l] = np[l]; m_wake[l] = nw[l];
            chk(mode_of(l) == m_mode[l], "R2 lane mode", mode_of(l), m_mode[l]);
        end
        for (int m = 0; m < 4; m++)
            chk(int'(residency[m*CW +: CW]) == m_res[m], "R10 residency",
                int'(residency[m*CW +: CW]), m_res[m]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, '0);
    endtask

    task automatic train(input int n);
        for (int k = 0; k < 12; k++) begin
            step('1, '0);
            idle(n);
        end
    endtask

    task automatic hold_count(input int cyc, output int cnt);
        cnt = 0;
        for (int i = 0; i < cyc; i++) begin
            step(4'b0001, '0);
            if (last_hold) cnt++;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int hc;
        int seg;
        int kind;
        logic [N-1:0] rq;
        logic [W*N-1:0] pk;
        for (int l = 0; l < N; l++) begin
            m_mode[l] = 0; m_idle[l] = 0; m_pred[l] = 0; m_wake[l] = 0;
        end
        for (int m = 0; m < 4; m++) m_res[m] = 0;
        repeat (3) @(posedge clk);
        #2;
        chk(lane_mode == '0, "R1 reset modes", int'(lane_mode), 0);
        chk(residency == '0, "R1 reset counters", int'(residency[CW-1:0]), 0);
        rst_n = 1'b1;
        #1;
        chk(issue_hold == 1'b0 && wake_req == '0, "R1 reset hold and wake",
            int'({issue_hold, wake_req}), 0);

        // power-leaning, long idle periods -> gated
        aggr = 1'b1;
        train(40);
        step('1, '0);
        idle(10);
        chk(mode_of(0) == 3, "R3 long period gated", mode_of(0), 3);
        hold_count(8, hc);
        chk(hc == 4, "R7 latency from gated", hc, 4);

        // short periods -> light scaling
        train(3);
        step('1, '0);
        idle(6);
        chk(mode_of(0) == 1, "R3 short period light", mode_of(0), 1);
        hold_count(4, hc);
        chk(hc == 1, "R7 latency from light", hc, 1);

        // medium periods -> deep scaling (prediction averaging, R9)
        train(15);
        step('1, '0);
        idle(6);
        chk(mode_of(0) == 2, "R3 R9 medium period deep", mode_of(0), 2);
        hold_count(4, hc);
        chk(hc == 2, "R7 latency from deep", hc, 2);

        // performance-leaning variant
        aggr = 1'b0;
        train(40);
        step('1, '0);
        idle(2);
        chk(mode_of(0) == 0, "R4 waits one window", mode_of(0), 0);
        idle(8);
        chk(mode_of(0) == 2, "R4 capped one level shallower", mode_of(0), 2);

        // look-ahead wake of a gated lane
        aggr = 1'b1;
        step('1, '0);
        idle(10);
        chk(mode_of(0) == 3, "R5 precondition gated", mode_of(0), 3);
        step('0, 16'h1000);
        chk(mode_of(0) == 0, "R5 look-ahead wakes lane", mode_of(0), 0);
        chk(mode_of(1) == 3, "R5 other lane untouched", mode_of(1), 3);
        step('0, 16'h0001);
        step('0, 16'h0010);
        chk(mode_of(0) == 0, "R5 no step-down under hit", mode_of(0), 0);
        step('0, 16'h0100);
        step(4'b0001, '0);
        chk(last_hold == 1'b0, "R7 pre-woken lane not held", int'(last_hold), 0);
        chk(mode_of(0) == 0, "R6 requested lane nominal", mode_of(0), 0);

        // random idle runs cut by requests and look-ahead hits
        for (int ph = 0; ph < 6; ph++) begin
            aggr = ph[0];
            for (int g = 0; g < 40; g++) begin
                kind = $urandom_range(0, 2);
                seg = (kind == 0) ? $urandom_range(1, 40) : $urandom_range(1, 4);
                for (int i = 0; i < seg; i++) begin
                    rq = (kind == 0) ? '0 : N'($urandom);
                    pk = ($urandom_range(0, 7) == 0) ? (W*N)'(1 << $urandom_range(0, W*N-1)) : '0;
                    step(rq, pk);
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule